// File: doc/BRIEF.md
# Dual-Compare Eight-Bit Pulse Timer

This block is an 8-bit up-counter that advances on each clock cycle in which a prescaled count-enable input is high. Two constant registers are compared against the counter. Each equality raises an event flag and can change a single waveform output pin. Either event can also restart the counter, and a wrap from the top value raises an overflow flag. Each of the three flags has its own enable bit and its own interrupt request line. A 2-bit code gives the highest-priority request that is currently pending.

Typical setup: the restart source is set to constant A, and the A action drives the pin high while the B action drives it low. The pin then carries a pulse train whose period is A+1 counts and whose high time is set by B. Software takes no part once this setup is written. A host reaches the registers through a simple single-cycle read/write port. Reads are combinational and writes are registered.

Top module: `cmp_timer8`

## Requirements
- R1: After reset, every register reads 0, the waveform output is 0, and all request lines and the priority code are 0.
- R2: The counter steps up by one on each cycle in which the count enable is high, and it wraps from 0xFF to 0x00. A host write to the counter loads the written value in that cycle. That write overrides counting, and no event is raised from that cycle.
- R3: The overflow flag (status bit 6) sets when a counted step takes the counter from 0xFF to 0x00 by increment.
- R4: The match-A flag (status bit 4) sets on a counted cycle in which the counter equals constant A. The match-B flag (status bit 5) sets in the same way against constant B.
- R5: Control bits [1:0] select the restart source: 01 restarts on a match with A, 10 restarts on a match with B, and 00 or 11 give no restart. On a restart, the counter is 0 after the matching count instead of stepping up.
- R6: Status bits [1:0] give the pin action for a match with A, and bits [3:2] give the action for a match with B. The codes are: 00 no change, 01 drive 0, 10 drive 1, 11 toggle. The pin changes on the clock edge that ends the matching cycle.
- R7: When both matches fall on the same count, a nonzero A action sets the pin. A B action applies only when the A action is 00.
- R8: Writing 0 to a status flag bit clears that flag only if a status read returned it as 1 since it last cleared. Writing 1 to a flag bit has no effect.
- R9: The request lines for A, B and overflow are high exactly while their flag is set and their enable is set. The enables are control bit 2 for A, bit 3 for B and bit 4 for overflow.
- R10: The 2-bit priority code gives the highest pending request: 01 for A, 10 for B, 11 for overflow, and 00 for none. A ranks above B, and B ranks above overflow.
- R11: The register addresses are: 0 control, 1 status, 2 constant A, 3 constant B, 4 counter. Other addresses read 0. The action code reads back in status bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_tick | input | 1 | Prescaled count enable |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (arms flags for clearing) |
| hst_addr | input | 3 | Register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data |
| wave_o | output | 1 | Waveform output pin |
| irq_a | output | 1 | Match-A request |
| irq_b | output | 1 | Match-B request |
| irq_ovf | output | 1 | Overflow request |
| irq_top | output | 2 | Highest pending request code |

## Verification
The bench drives a pulse pattern with restart on A and checks the pin at several counts. A wrong restart edge would stretch the period by one count, and swapped action pairs would invert the pulse. It places both matches on a single count with opposing actions. A design that let B win would leave the pin at the wrong level. It writes 0 to a flag that has not been read and expects the flag to survive. It writes to the counter while the count enable is high and expects the written value, which an encoding that counted first would miss. It also raises all three requests at once and clears them one by one to walk the priority code.

// File: rtl/cmp_timer8_pkg.sv
package cmp_timer8_pkg;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_ON_A = 2'b01,
    CLR_ON_B = 2'b10,
    CLR_RSV  = 2'b11
  } clr_sel_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } pin_act_e;

  localparam int NUM_EVT   = 3;
  localparam int EVT_A     = 0;
  localparam int EVT_B     = 1;
  localparam int EVT_OVF   = 2;
  localparam int TOP_W     = $clog2(NUM_EVT + 1);

  localparam int CTL_CLR_LSB = 0;
  localparam int CTL_IE_LSB  = 2;
  localparam int CTL_BITS    = CTL_IE_LSB + NUM_EVT;
  localparam int STS_FLG_LSB = 4;
  localparam int CODE_W      = 4;

  localparam int ADR_CTRL = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_CSTA = 2;
  localparam int ADR_CSTB = 3;
  localparam int ADR_CNT  = 4;

endpackage

// File: rtl/cmp_timer8_rstsync.sv
module cmp_timer8_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/cmp_timer8_count.sv
module cmp_timer8_count
  import cmp_timer8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic [DW-1:0] cst_a,
  input  logic [DW-1:0] cst_b,
  input  clr_sel_e      clr_sel,
  output logic [DW-1:0] cnt_q,
  output logic          hit_a,
  output logic          hit_b,
  output logic          wrap
);
  localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};

  logic          evt_ok;
  logic          restart;
  logic          cnt_en;
  logic [DW-1:0] cnt_n;

  always_comb begin
    evt_ok  = tick && !ld;
    hit_a   = evt_ok && (cnt_q == cst_a);
    hit_b   = evt_ok && (cnt_q == cst_b);
    restart = ((clr_sel == CLR_ON_A) && hit_a) ||
              ((clr_sel == CLR_ON_B) && hit_b);
    wrap    = evt_ok && (cnt_q == CNT_MAX) && !restart;
    cnt_en  = ld || evt_ok;
    if (ld)           cnt_n = ld_val;
    else if (restart) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && clr_sel == CLR_NONE) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_restart_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && clr_sel == CLR_ON_A && cnt_q == cst_a) |=> (cnt_q == '0));

  p_restart_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && clr_sel == CLR_ON_B && cnt_q == cst_b) |=> (cnt_q == '0));

endmodule

// File: rtl/cmp_timer8_flags.sv
module cmp_timer8_flags
  import cmp_timer8_pkg::*;
#(
  parameter int N = NUM_EVT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_evt,
  input  logic             rd_stat,
  input  logic             wr_stat,
  input  logic [N-1:0]     wr_bits,
  input  logic [N-1:0]     ien,
  output logic [N-1:0]     flag_q,
  output logic [N-1:0]     req,
  output logic [TOP_W-1:0] top
);
  logic [N-1:0] arm_q;
  logic [N-1:0] flag_n;
  logic [N-1:0] arm_n;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clr_hit;

    always_comb begin
      clr_hit = wr_stat && !wr_bits[i] && arm_q[i];
      if (set_evt[i])   flag_n[i] = 1'b1;
      else if (clr_hit) flag_n[i] = 1'b0;
      else              flag_n[i] = flag_q[i];
      if (rd_stat && flag_q[i]) arm_n[i] = 1'b1;
      else if (clr_hit)         arm_n[i] = 1'b0;
      else                      arm_n[i] = arm_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        flag_q[i] <= flag_n[i];
        arm_q[i]  <= arm_n[i];
      end
    end

    p_clear_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |-> $past(arm_q[i]));

    p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flag_q[i]);
  end

  assign req = flag_q & ien;

  always_comb begin
    top = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) top = TOP_W'(k + 1);
    end
  end

endmodule

// File: rtl/cmp_timer8_wave.sv
module cmp_timer8_wave
  import cmp_timer8_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit_a,
  input  logic     hit_b,
  input  pin_act_e act_a,
  input  pin_act_e act_b,
  output logic     wave_q
);
  pin_act_e sel_act;
  logic     wave_n;

  always_comb begin
    if (hit_a && act_a != ACT_HOLD) sel_act = act_a;
    else if (hit_b)                 sel_act = act_b;
    else                            sel_act = ACT_HOLD;
    case (sel_act)
      ACT_LOW:  wave_n = 1'b0;
      ACT_HIGH: wave_n = 1'b1;
      ACT_TOG:  wave_n = !wave_q;
      default:  wave_n = wave_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_n;
  end

  p_a_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && act_a == ACT_HIGH) |=> wave_q);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_a && !hit_b) |=> $stable(wave_q));

  p_a_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && hit_b && act_a == ACT_LOW) |=> !wave_q);

endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
  import cmp_timer8_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             hst_wr,
  input  logic             hst_rd,
  input  logic [AW-1:0]    hst_addr,
  input  logic [DW-1:0]    hst_wdata,
  output logic [DW-1:0]    hst_rdata,
  output logic             wave_o,
  output logic             irq_a,
  output logic             irq_b,
  output logic             irq_ovf,
  output logic [TOP_W-1:0] irq_top
);
  logic rst_i_n;

  cmp_timer8_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  logic [CTL_BITS-1:0] ctrl_q, ctrl_n;
  logic [CODE_W-1:0]   code_q, code_n;
  logic [DW-1:0]       csta_q, csta_n;
  logic [DW-1:0]       cstb_q, cstb_n;
  logic wr_ctrl, wr_stat, wr_csta, wr_cstb, wr_cnt, rd_stat;

  always_comb begin
    wr_ctrl = hst_wr && (hst_addr == AW'(ADR_CTRL));
    wr_stat = hst_wr && (hst_addr == AW'(ADR_STAT));
    wr_csta = hst_wr && (hst_addr == AW'(ADR_CSTA));
    wr_cstb = hst_wr && (hst_addr == AW'(ADR_CSTB));
    wr_cnt  = hst_wr && (hst_addr == AW'(ADR_CNT));
    rd_stat = hst_rd && (hst_addr == AW'(ADR_STAT));
    ctrl_n  = wr_ctrl ? hst_wdata[CTL_BITS-1:0] : ctrl_q;
    code_n  = wr_stat ? hst_wdata[CODE_W-1:0]   : code_q;
    csta_n  = wr_csta ? hst_wdata : csta_q;
    cstb_n  = wr_cstb ? hst_wdata : cstb_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= '0;
      code_q <= '0;
      csta_q <= '0;
      cstb_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      code_q <= code_n;
      csta_q <= csta_n;
      cstb_q <= cstb_n;
    end
  end

  logic [DW-1:0] cnt_q;
  logic          hit_a, hit_b, wrap;

  cmp_timer8_count #(.DW(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .tick    (cnt_tick),
    .ld      (wr_cnt),
    .ld_val  (hst_wdata),
    .cst_a   (csta_q),
    .cst_b   (cstb_q),
    .clr_sel (clr_sel_e'(ctrl_q[CTL_CLR_LSB +: 2])),
    .cnt_q   (cnt_q),
    .hit_a   (hit_a),
    .hit_b   (hit_b),
    .wrap    (wrap)
  );

  logic [NUM_EVT-1:0] set_evt, flag_q, req;

  always_comb begin
    set_evt          = '0;
    set_evt[EVT_A]   = hit_a;
    set_evt[EVT_B]   = hit_b;
    set_evt[EVT_OVF] = wrap;
  end

  cmp_timer8_flags #(.N(NUM_EVT)) u_flg (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .set_evt (set_evt),
    .rd_stat (rd_stat),
    .wr_stat (wr_stat),
    .wr_bits (hst_wdata[STS_FLG_LSB +: NUM_EVT]),
    .ien     (ctrl_q[CTL_IE_LSB +: NUM_EVT]),
    .flag_q  (flag_q),
    .req     (req),
    .top     (irq_top)
  );

  cmp_timer8_wave u_wave (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .act_a  (pin_act_e'(code_q[1:0])),
    .act_b  (pin_act_e'(code_q[3:2])),
    .wave_q (wave_o)
  );

  assign irq_a   = req[EVT_A];
  assign irq_b   = req[EVT_B];
  assign irq_ovf = req[EVT_OVF];

  always_comb begin
    case (hst_addr)
      AW'(ADR_CTRL): hst_rdata = DW'(ctrl_q);
      AW'(ADR_STAT): hst_rdata = DW'({flag_q, code_q});
      AW'(ADR_CSTA): hst_rdata = csta_q;
      AW'(ADR_CSTB): hst_rdata = cstb_q;
      AW'(ADR_CNT):  hst_rdata = cnt_q;
      default:       hst_rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^hst_wdata[DW-1:STS_FLG_LSB + NUM_EVT];

  p_top_a_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_top == TOP_W'(1)) |-> irq_a);

  p_top_none_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!irq_a && !irq_b && !irq_ovf) |-> (irq_top == '0));

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cnt_tick && !wr_cnt && cnt_q == {DW{1'b1}} &&
     ctrl_q[CTL_CLR_LSB +: 2] == 2'b00) |=> flag_q[EVT_OVF]);

endmodule

// File: tb/cmp_timer8_tb_top.sv
module cmp_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_tick;
  logic       hst_wr, hst_rd;
  logic [2:0] hst_addr;
  logic [7:0] hst_wdata;
  logic [7:0] hst_rdata;
  logic       wave_o, irq_a, irq_b, irq_ovf;
  logic [1:0] irq_top;

  always #5 clk = ~clk;

  cmp_timer8 dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .wave_o(wave_o),
    .irq_a(irq_a), .irq_b(irq_b), .irq_ovf(irq_ovf), .irq_top(irq_top)
  );

  typedef struct {
    string      req;
    string      what;
    logic [7:0] val;
    logic [7:0] mask;
  } item_t;

  item_t exp_q[$];
  logic [7:0] act_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic push_exp(string req, string what, logic [7:0] v, logic [7:0] m);
    item_t it;
    it.req = req; it.what = what; it.val = v; it.mask = m;
    exp_q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      while (exp_q.size() != 0 && act_q.size() != 0) begin
        item_t it;
        logic [7:0] a;
        it = exp_q.pop_front();
        a  = act_q.pop_front();
        total++;
        if ((a & it.mask) !== (it.val & it.mask)) begin
          bad++;
          $display("FAIL %s %s: actual=%02h expected=%02h mask=%02h",
                   it.req, it.what, a, it.val, it.mask);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic chk_reg(string req, string what, input logic [2:0] a,
                         input logic [7:0] e, input logic [7:0] m);
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = a;
    #1;
    push_exp(req, what, e, m);
    act_q.push_back(hst_rdata);
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic chk_pins(string req, string what, input logic [7:0] e);
    @(negedge clk);
    #1;
    push_exp(req, what, e, 8'hFF);
    act_q.push_back({3'b000, irq_top, irq_ovf, irq_b, irq_a});
  endtask

  task automatic chk_wave(string req, string what, input logic e);
    @(negedge clk);
    #1;
    push_exp(req, what, {7'd0, e}, 8'h01);
    act_q.push_back({7'd0, wave_o});
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cnt_tick = 1'b0; hst_wr = 1'b0; hst_rd = 1'b0;
    hst_addr = '0; hst_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R11 reset state and map
    chk_reg("R1", "ctrl reset", 3'd0, 8'h00, 8'hFF);
    chk_reg("R1", "status reset", 3'd1, 8'h00, 8'hFF);
    chk_reg("R1", "const A reset", 3'd2, 8'h00, 8'hFF);
    chk_reg("R1", "const B reset", 3'd3, 8'h00, 8'hFF);
    chk_reg("R1", "counter reset", 3'd4, 8'h00, 8'hFF);
    chk_reg("R11", "unused address", 3'd5, 8'h00, 8'hFF);
    chk_pins("R1", "irq pins reset", 8'h00);
    chk_wave("R1", "wave reset", 1'b0);

    // R2 counting and wrap, R3 overflow, R9 gate
    wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h00);
    ticks(5);
    chk_reg("R2", "count five", 3'd4, 8'h05, 8'hFF);
    wr(3'd4, 8'hFE);
    ticks(2);
    chk_reg("R2", "wrap to zero", 3'd4, 8'h00, 8'hFF);
    chk_pins("R9", "flag without enable", 8'h00);
    wr(3'd0, 8'h10);
    chk_pins("R3", "overflow request", 8'h1C);

    // R8 clear only after read
    wr(3'd1, 8'h00);
    chk_pins("R8", "unread flag kept", 8'h1C);
    chk_reg("R8", "status shows overflow", 3'd1, 8'h40, 8'h70);
    wr(3'd1, 8'h00);
    chk_pins("R8", "armed flag cleared", 8'h00);
    wr(3'd1, 8'h40);
    chk_pins("R8", "write one ignored", 8'h00);

    // R2 host write beats counting
    @(negedge clk);
    cnt_tick = 1'b1; hst_wr = 1'b1; hst_addr = 3'd4; hst_wdata = 8'h20;
    @(negedge clk);
    cnt_tick = 1'b0; hst_wr = 1'b0;
    chk_reg("R2", "write wins over tick", 3'd4, 8'h20, 8'hFF);

    // R5 restart on A, R4 flag
    wr(3'd0, 8'h01); wr(3'd2, 8'h04); wr(3'd4, 8'h00);
    ticks(5);
    chk_reg("R5", "restart on A", 3'd4, 8'h00, 8'hFF);
    chk_reg("R4", "match A flag", 3'd1, 8'h10, 8'h10);
    ticks(3);
    chk_reg("R5", "count after restart", 3'd4, 8'h03, 8'hFF);

    // R5 restart on B
    wr(3'd0, 8'h02); wr(3'd3, 8'h06); wr(3'd2, 8'h80); wr(3'd4, 8'h00);
    ticks(7);
    chk_reg("R5", "restart on B", 3'd4, 8'h00, 8'hFF);
    ticks(2);
    chk_reg("R5", "count after B restart", 3'd4, 8'h02, 8'hFF);

    // R5 encoding 11 does not restart
    wr(3'd0, 8'h03); wr(3'd2, 8'h03); wr(3'd3, 8'h80); wr(3'd4, 8'h00);
    ticks(5);
    chk_reg("R5", "reserved code no restart", 3'd4, 8'h05, 8'hFF);

    // R6 pulse train: A drives high and restarts, B drives low
    wr(3'd0, 8'h01); wr(3'd2, 8'h09); wr(3'd3, 8'h03);
    wr(3'd1, 8'h06);
    chk_reg("R11", "action code readback", 3'd1, 8'h06, 8'h0F);
    wr(3'd4, 8'h00);
    ticks(10);
    chk_wave("R6", "high after match A", 1'b1);
    chk_reg("R6", "period restart", 3'd4, 8'h00, 8'hFF);
    ticks(3);
    chk_wave("R6", "still high before B", 1'b1);
    ticks(1);
    chk_wave("R6", "low after match B", 1'b0);
    ticks(6);
    chk_wave("R6", "high next period", 1'b1);

    // R6 toggle
    wr(3'd0, 8'h00); wr(3'd1, 8'h03); wr(3'd2, 8'h10); wr(3'd3, 8'h80);
    wr(3'd4, 8'h10);
    ticks(1);
    chk_wave("R6", "toggle low", 1'b0);
    wr(3'd4, 8'h10);
    ticks(1);
    chk_wave("R6", "toggle high", 1'b1);

    // R7 same count: A wins unless A holds
    wr(3'd2, 8'h30); wr(3'd3, 8'h30);
    wr(3'd1, 8'h01); wr(3'd4, 8'h30); ticks(1);
    chk_wave("R7", "A low alone", 1'b0);
    wr(3'd1, 8'h06); wr(3'd4, 8'h30); ticks(1);
    chk_wave("R7", "A high over B low", 1'b1);
    wr(3'd1, 8'h09); wr(3'd4, 8'h30); ticks(1);
    chk_wave("R7", "A low over B high", 1'b0);
    wr(3'd1, 8'h08); wr(3'd4, 8'h30); ticks(1);
    chk_wave("R7", "B applies when A holds", 1'b1);

    // R10 priority walk, R9 lines
    chk_reg("R8", "arm all flags", 3'd1, 8'h30, 8'h30);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h1C);
    chk_pins("R9", "no flags no lines", 8'h00);
    wr(3'd2, 8'h02); wr(3'd3, 8'h01); wr(3'd4, 8'h00);
    ticks(3);
    wr(3'd4, 8'hFF);
    ticks(1);
    chk_pins("R10", "all pending, A first", 8'h0F);
    chk_reg("R4", "all flags set", 3'd1, 8'h70, 8'h70);
    wr(3'd1, 8'h60);
    chk_pins("R10", "B next", 8'h16);
    wr(3'd1, 8'h40);
    chk_pins("R10", "overflow last", 8'h1C);
    wr(3'd1, 8'h00);
    chk_pins("R10", "none pending", 8'h00);

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d/%0d expected=0/0 leftover",
               exp_q.size(), act_q.size());
    end
    done = 1;
    finish_run();
  end
endmodule